// File: doc/BRIEF.md
# Nibble-ADPCM Block Decoder

This block turns a stream of bytes held in an external FIFO into 8-bit offset-binary audio samples. It has two modes. In raw mode, each sample request pops one byte and passes it through unchanged. In decode mode, bytes are grouped into packets. Each packet is one header byte followed by fourteen data bytes. Each data byte carries two 4-bit codes, so a packet yields 28 samples.

For every code, the decoder:
- places the code at the top of a 16-bit word;
- scales it down by the shift amount from the header;
- adds a second-order prediction built from the last two outputs and a pair of programmable signed 8-bit coefficients chosen by the header;
- saturates the result to 16 bits;
- converts it to unsigned 8-bit audio.

The audio sink asks for one sample at a time with `sample_req`. It may only do so while `ready` is high. When the FIFO cannot supply a byte that is needed, the decoder returns silence (0x80) and its state does not move. A FIFO clear sends the decoder back to waiting for a header.

Top module: `nibble_adpcm_dec`

## Requirements
- R1: When `mode_ctrl & 8'h83` differs from `8'h82`, the block is in raw mode. An accepted request on a non-empty FIFO pops exactly one byte, and that byte appears unchanged on `out_sample`.
- R2: When a byte is needed but `fifo_empty` is high, the request yields `out_sample = 8'h80` with no pop. Packet position, history and header do not change.
- R3: In decode mode, the first request of a packet pops the header byte in its first cycle. The low nibble (bits 3:0) is the shift amount and the high nibble (bits 7:4) is the filter index f. `ready` is low for the one following cycle, and the sample is delivered one cycle later than in the other cases.
- R4: Filter index f selects coefficient c1 at bank address 2f and c0 at address 2f+1. Both are two's-complement bytes written through `coef_we`/`coef_addr`/`coef_wdata`.
- R5: Even sample positions 0, 2, …, 26 pop a new data byte and use its bits 3:0. Odd positions use bits 7:4 of the same byte and pop nothing.
- R6: The 4-bit code is placed in bits 15:12 of a signed 16-bit word, then arithmetically shifted right by the shift amount.
- R7: The prediction (h0·c0 + h1·c1 + 32) >>> 6 is added to the shifted code. Here h0 is the previous decoded value and h1 the one before it.
- R8: The sum is clamped to −32768..32767. The clamped value becomes the new h0, and the old h0 becomes h1.
- R9: The output byte is the clamped value divided by 256, truncated toward zero, with bit 7 inverted.
- R10: After the sample at position 27, the next request starts a new packet with a header pop.
- R11: A `fifo_clr` pulse returns the decoder to awaiting a header at position 0.
- R12: After reset, h0 and h1 are zero and every coefficient is zero.
- R13: Outside the header case of R3, `out_valid` pulses for one cycle in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ctrl | input | 8 | Channel control byte; decode when masked with 0x83 equals 0x82 |
| fifo_clr | input | 1 | FIFO reset pulse, restarts packet sequencing |
| coef_we | input | 1 | Coefficient bank write enable |
| coef_addr | input | 5 | Coefficient bank address |
| coef_wdata | input | 8 | Coefficient byte, two's complement |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head byte this cycle |
| sample_req | input | 1 | Request one output sample, honoured while ready is high |
| ready | output | 1 | Decoder can accept a request |
| out_valid | output | 1 | Output sample is valid this cycle |
| out_sample | output | 8 | Unsigned 8-bit audio sample |

## Verification
The checks that hold on every cycle are protocol and range rules:
- no pop while the FIFO is empty;
- an accepted request that needs a byte from an empty FIFO yields silence on the next cycle;
- odd positions never pop;
- the header stall lasts exactly one cycle;
- the packet position stays below 28.

The bench is needed for the arithmetic, which no single-cycle property can cover: the coefficient selection by filter index, shift, prediction with rounding, saturation and the truncate-toward-zero conversion. It compares every sample against an integer model. The packet sweep covers all shifts and filter indices, including saturating coefficient pairs, underruns directly after a header and in mid-packet, and a clear in mid-packet.

// File: rtl/nibble_adpcm_dec.sv
module nibble_adpcm_dec #(
  parameter int PKT_SAMPLES = 28,
  parameter int NUM_FILT    = 16,
  localparam int CAW = $clog2(2 * NUM_FILT),
  localparam int PW  = $clog2(PKT_SAMPLES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     mode_ctrl,
  input  logic           fifo_clr,
  input  logic           coef_we,
  input  logic [CAW-1:0] coef_addr,
  input  logic [7:0]     coef_wdata,
  input  logic           fifo_empty,
  input  logic [7:0]     fifo_data,
  output logic           fifo_pop,
  input  logic           sample_req,
  output logic           ready,
  output logic           out_valid,
  output logic [7:0]     out_sample
);

  logic [7:0] coef [2*NUM_FILT];
  logic              hdr_need, busy;
  logic [PW-1:0]     pos;
  logic [3:0]        shamt;
  logic [CAW-2:0]    filt;
  logic [7:0]        dbyte;
  logic signed [15:0] h0, h1;

  wire decode    = (mode_ctrl & 8'h83) == 8'h82;
  wire act       = (sample_req && !busy) || busy;
  wire need_byte = !decode || hdr_need || !pos[0];
  wire silence   = act && need_byte && fifo_empty;
  wire hdr_step  = act && decode && hdr_need && !fifo_empty;
  wire emit      = act && !hdr_step;
  wire last_pos  = pos == PW'(PKT_SAMPLES - 1);

  assign ready    = !busy;
  assign fifo_pop = act && need_byte && !fifo_empty;

  wire [3:0] nib = pos[0] ? dbyte[7:4] : fifo_data[3:0];
  wire signed [7:0] c1 = $signed(coef[{filt, 1'b0}]);
  wire signed [7:0] c0 = $signed(coef[{filt, 1'b1}]);

  logic signed [15:0] shv;
  logic signed [24:0] p0, p1, acc, pr;
  logic signed [25:0] sum;
  logic signed [15:0] sat;
  logic [7:0]         q;

  always_comb begin
    shv = $signed({nib, 12'h000}) >>> shamt;
    p0  = $signed({{9{h0[15]}}, h0}) * $signed({{17{c0[7]}}, c0});
    p1  = $signed({{9{h1[15]}}, h1}) * $signed({{17{c1[7]}}, c1});
    acc = p0 + p1 + 25'sd32;
    pr  = acc >>> 6;
    sum = $signed({{10{shv[15]}}, shv}) + $signed({pr[24], pr});
    if (sum > 26'sd32767)       sat = 16'sh7fff;
    else if (sum < -26'sd32768) sat = 16'sh8000;
    else                        sat = sum[15:0];
    q = sat[15:8] + ((sat[15] && |sat[7:0]) ? 8'd1 : 8'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2 * NUM_FILT; i++) coef[i] <= '0;
    end else if (coef_we) begin
      coef[coef_addr] <= coef_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_need <= 1'b1; busy <= 1'b0; pos <= '0; shamt <= '0; filt <= '0;
      dbyte <= '0; h0 <= '0; h1 <= '0; out_valid <= 1'b0; out_sample <= 8'h80;
    end else if (fifo_clr) begin
      hdr_need <= 1'b1; busy <= 1'b0; pos <= '0; out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      busy      <= hdr_step;
      if (emit)
        out_sample <= silence ? 8'h80 : (decode ? (q ^ 8'h80) : fifo_data);
      if (hdr_step) begin
        shamt    <= fifo_data[3:0];
        filt     <= fifo_data[7:4];
        hdr_need <= 1'b0;
        pos      <= '0;
      end
      if (emit && decode && !silence) begin
        h1 <= h0;
        h0 <= sat;
        if (!pos[0]) dbyte <= fifo_data;
        pos <= last_pos ? '0 : pos + 1'b1;
        if (last_pos) hdr_need <= 1'b1;
      end
    end
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty); // R2
  AST_UNDERRUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    (sample_req && ready && need_byte && fifo_empty) |=> (out_valid && out_sample == 8'h80)); // R2
  AST_ODD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_req && ready && decode && !hdr_need && pos[0]) |-> !fifo_pop); // R5
  AST_HDR_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    !ready |=> ready); // R3
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos < PW'(PKT_SAMPLES)); // R10
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    (sample_req && ready && !(decode && hdr_need && !fifo_empty)) |=> out_valid); // R13

endmodule

// File: tb/nibble_adpcm_dec_tb_top.sv
module nibble_adpcm_dec_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [7:0] mode_ctrl = 8'h80, coef_wdata = 0, out_sample;
  logic       fifo_clr = 0, coef_we = 0, sample_req = 0;
  logic [4:0] coef_addr = 0;
  logic       fifo_pop, ready, out_valid;

  logic [7:0] mem [4096];
  int rd = 0, wr = 0;
  wire       fifo_empty = (rd == wr);
  wire [7:0] fifo_data  = mem[rd % 4096];
  always @(posedge clk) if (fifo_pop && rd != wr) rd <= rd + 1;

  nibble_adpcm_dec dut_i (.clk, .rst_n, .mode_ctrl, .fifo_clr, .coef_we, .coef_addr,
    .coef_wdata, .fifo_empty, .fifo_data, .fifo_pop, .sample_req, .ready,
    .out_valid, .out_sample);

  int checks = 0, errors = 0;
  int cm [32];
  int m_h0 = 0, m_h1 = 0, m_pos = 0, m_sh = 0, m_f = 0;
  bit m_hdr = 1;
  int m_byte = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[7:0];
  endfunction

  task automatic push(logic [7:0] b);
    mem[wr % 4096] = b;
    wr++;
  endtask

  task automatic wr_coef(int a, int v);
    @(negedge clk);
    coef_we = 1; coef_addr = a[4:0]; coef_wdata = v[7:0];
    @(negedge clk);
    coef_we = 0;
    cm[a] = v;
  endtask

  task automatic one_sample(string gtag);
    int avail, idx, pops, lat, exp, nib, d, pred, t, rd0, got_lat;
    bit dec, silent, clamp;
    string tag;
    dec = (mode_ctrl & 8'h83) == 8'h82;
    avail = wr - rd; idx = rd; pops = 0; lat = 1; silent = 0; clamp = 0; exp = 128;
    tag = gtag;
    if (!dec) begin
      if (avail > 0) begin exp = mem[idx % 4096]; pops = 1; end
      else begin silent = 1; tag = "R2"; end
    end else begin
      if (m_hdr) begin
        if (avail == 0) begin silent = 1; tag = "R2"; end
        else begin
          m_sh = mem[idx % 4096] & 15; m_f = mem[idx % 4096] >> 4;
          idx++; pops = 1; avail--; lat = 2; m_hdr = 0; m_pos = 0; tag = "R3";
        end
      end
      if (!silent) begin
        if (m_pos % 2 == 0) begin
          if (avail == 0) begin silent = 1; tag = "R2"; end
          else begin m_byte = mem[idx % 4096]; pops++; nib = m_byte & 15; end
        end else nib = m_byte >> 4;
      end
      if (!silent) begin
        d = nib << 12;
        if (d >= 32768) d -= 65536;
        d = d >>> m_sh;
        pred = (m_h0 * cm[2*m_f+1] + m_h1 * cm[2*m_f] + 32) >>> 6;
        t = d + pred;
        if (t > 32767) begin t = 32767; clamp = 1; end
        if (t < -32768) begin t = -32768; clamp = 1; end
        exp = ((t / 256) & 255) ^ 128;
        if (clamp) tag = "R8";
        else if (m_f == 0 && tag == "R7") tag = "R6";
        else if (m_pos == 27) tag = "R10";
        else if (t < 0 && (t % 256) != 0 && tag == "R7") tag = "R9";
        else if (tag == "R7" && m_f % 2 == 0) tag = "R4";
        m_h1 = m_h0; m_h0 = t; m_pos++;
        if (m_pos == 28) begin m_pos = 0; m_hdr = 1; end
      end
    end
    while (!ready) @(negedge clk);
    rd0 = rd;
    sample_req = 1;
    @(negedge clk);
    sample_req = 0;
    got_lat = 1;
    if (lat == 2) chk(!ready && !out_valid, "R3", {ready, out_valid}, 0);
    while (!out_valid && got_lat < 4) begin @(negedge clk); got_lat++; end
    chk(got_lat == lat, (lat == 2) ? "R3" : "R13", got_lat, lat);
    chk(out_sample == exp[7:0], tag, out_sample, exp);
    chk(rd - rd0 == pops, (pops == 0 && !silent) ? "R5" : tag, rd - rd0, pops);
    @(negedge clk);
    chk(!out_valid, "R13", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) cm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready == 1, "R12", ready, 1);
    chk(out_valid == 0, "R12", out_valid, 0);
    chk(fifo_pop == 0, "R12", fifo_pop, 0);

    // R1 raw pass-through under several control bytes, then underrun
    foreach (mode_ctrl_vals[k]) ;
    for (int m = 0; m < 4; m++) begin
      mode_ctrl = (m == 0) ? 8'h80 : (m == 1) ? 8'h00 : (m == 2) ? 8'h83 : 8'h02;
      for (int i = 0; i < 6; i++) push(rnd());
      for (int i = 0; i < 8; i++) one_sample("R1");
    end

    // R12 first decode packet with zero coefficients and zero history
    mode_ctrl = 8'hA2;
    push(8'h00);
    for (int i = 0; i < 14; i++) push(rnd());
    one_sample("R12");
    for (int i = 1; i < 28; i++) one_sample("R6");

    // R4 coefficient bank programming, including saturating pairs
    for (int f = 0; f < 16; f++) begin
      int a, b;
      a = $signed(rnd()); b = $signed(rnd());
      if (f == 0) begin a = 0; b = 0; end
      if (f == 1) begin a = 127; b = 127; end
      if (f == 2) begin a = -128; b = 127; end
      if (f == 3) begin a = -64; b = 127; end
      wr_coef(2*f, a);
      wr_coef(2*f+1, b);
    end

    // R7 packet sweep over every shift and filter index
    for (int pk = 0; pk < 48; pk++) begin
      push(8'((((pk % 16) << 4) | ((pk * 7 + pk / 16) % 16))));
      for (int i = 0; i < 14; i++) push((pk % 5 == 1) ? 8'h77 : (pk % 5 == 2) ? 8'h88 : rnd());
      for (int i = 0; i < 28; i++) one_sample("R7");
    end

    // R2 underrun right after the header, then mid-packet
    push(8'h14);
    one_sample("R2");
    one_sample("R2");
    push(rnd()); push(rnd());
    for (int i = 0; i < 4; i++) one_sample("R7");
    one_sample("R2");
    one_sample("R2");
    for (int i = 0; i < 12; i++) push(rnd());
    for (int i = 4; i < 28; i++) one_sample("R10");

    // R11 clear in mid-packet restarts at a header
    push(8'h35);
    for (int i = 0; i < 14; i++) push(rnd());
    for (int i = 0; i < 5; i++) one_sample("R7");
    @(negedge clk);
    fifo_clr = 1; rd = wr;
    @(negedge clk);
    fifo_clr = 0;
    m_hdr = 1; m_pos = 0;
    chk(ready == 1, "R11", ready, 1);
    push(8'h22);
    for (int i = 0; i < 14; i++) push(rnd());
    one_sample("R11");
    for (int i = 1; i < 28; i++) one_sample("R7");
    one_sample("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int mode_ctrl_vals [1];
endmodule